// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-page to physical-frame mappings. Every valid entry is compared against the page number of a request in the same cycle. A hit returns the physical address one cycle later, built from the stored frame number and the untouched 12-bit page offset, together with the entry's read, write, execute and dirty bits. A request whose access type is not allowed by those bits reports a protection fault and returns no address. A miss raises a walk request that carries the page number. The table walker answers through the fill port, and the requester issues the lookup again.

Software-visible table changes reach the block through two inputs. A flush clears every entry, and is used when the table base changes on a process switch. An invalidate clears the one entry whose page number matches, and is used when a single table entry is rewritten. The entry count is a parameter, meant for 64 to 256 entries. On a fill, the block first reuses an entry that already holds the same page, then the lowest-numbered empty entry, and otherwise a round-robin victim.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, rsp_valid and walk_req are low, and the first lookup of any page misses.
- R2: A lookup presented in cycle N is answered in cycle N+1 with rsp_valid high. On a permitted hit, rsp_hit=1 and rsp_paddr = {stored frame, lk_vaddr[11:0]}. rsp_rd, rsp_wr, rsp_ex and rsp_dirty return the stored bits on every hit and are 0 on a miss.
- R3: A lookup that matches no valid entry gives rsp_hit=0, rsp_fault=0 and rsp_paddr=0. In the same cycle walk_req=1 and walk_vpn = lk_vaddr[VA_W-1:12]. walk_vpn is 0 whenever walk_req is 0.
- R4: A fill writes a valid entry that lookups from the next cycle onward hit. A lookup in the same cycle as the fill sees the table as it was before the fill.
- R5: A fill whose page is not already present goes to the lowest-numbered invalid entry when one exists, and it does not move the round-robin pointer.
- R6: When every entry is valid and the fill page is new, the entry named by a round-robin pointer is replaced. The pointer starts at 0 after reset, advances by one after each such replacement, and wraps from ENTRIES-1 to 0.
- R7: A fill whose page matches a valid entry overwrites that entry in place, so no page is ever held twice and no other entry is lost.
- R8: lk_kind is encoded 00 read, 01 write, 10 execute and 11 read. A hit whose permission bit for that kind is 0 gives rsp_hit=1, rsp_fault=1 and rsp_paddr=0.
- R9: flush clears every entry at the next edge. A fill in the same cycle as a flush is discarded.
- R10: An invalidate clears only the entry that holds inv_vpn. A fill of the same page in the same cycle is discarded, so the page ends up absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 read |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_fault | output | 1 | Matched, but the access type is not permitted |
| rsp_paddr | output | PA_W | Physical address, 0 on a miss or fault |
| rsp_rd | output | 1 | Stored read permission |
| rsp_wr | output | 1 | Stored write permission |
| rsp_ex | output | 1 | Stored execute permission |
| rsp_dirty | output | 1 | Stored dirty bit |
| walk_req | output | 1 | Miss: table walk wanted |
| walk_vpn | output | VA_W-12 | Page number to walk |
| fill_valid | input | 1 | Install strobe from the walker |
| fill_vpn | input | VA_W-12 | Page number to install |
| fill_ppn | input | PA_W-12 | Frame number to install |
| fill_rd | input | 1 | Read permission to install |
| fill_wr | input | 1 | Write permission to install |
| fill_ex | input | 1 | Execute permission to install |
| fill_dirty | input | 1 | Dirty bit to install |
| flush | input | 1 | Clear all entries |
| inv_valid | input | 1 | Clear one entry strobe |
| inv_vpn | input | VA_W-12 | Page number to clear |

## Verification
The checks on single matches and on walk requests assume two things about the inputs. The walker never installs a page that is not wanted, and no caller creates duplicates by other means. The fill port's overwrite rule keeps that true as long as all writes pass through it. The checks on address offsets and on flushes assume the inputs are stable across each clock edge. The bench drives every input on the falling edge, holds each strobe for exactly one cycle, and uses distinct page numbers except where a test sets out to repeat one. A run of lookups covers every stored page with every access kind.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int PAGE_OFF_W = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_READ2 = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic dirty;
    } perm_t;

    function automatic logic perm_allows(perm_t p, acc_kind_e k);
        case (k)
            ACC_WRITE: perm_allows = p.wr;
            ACC_EXEC:  perm_allows = p.ex;
            default:   perm_allows = p.rd;
        endcase
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [VPN_W-1:0]   tags [ENTRIES],
    input  logic [VPN_W-1:0]   key,
    output logic [ENTRIES-1:0] hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] dup_hit,
    input  logic               fire,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_dup;
    logic             any_free;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (dup_hit[i]) dup_idx = IDX_W'(i);
            if (!vld[i])    free_idx = IDX_W'(i);
        end
        any_dup  = |dup_hit;
        any_free = ~&vld;
        if (any_dup)       idx = dup_idx;
        else if (any_free) idx = free_idx;
        else               idx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fire && !any_dup && !any_free) begin
            if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
            else                             rr_q <= rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_tag,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  perm_t              wr_perm,
    input  logic [ENTRIES-1:0] clr_vec,
    output logic [ENTRIES-1:0] vld,
    output logic [VPN_W-1:0]   tags  [ENTRIES],
    output logic [PPN_W-1:0]   ppns  [ENTRIES],
    output perm_t              perms [ENTRIES]
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld[i] <= 1'b0;
            end else if (clr_vec[i]) begin
                vld[i] <= 1'b0;
            end else if (hit_wr) begin
                vld[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                tags[i]  <= wr_tag;
                ppns[i]  <= wr_ppn;
                perms[i] <= wr_perm;
            end
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       lk_valid,
    input  logic [VA_W-1:0]            lk_vaddr,
    input  logic [1:0]                 lk_kind,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic                       rsp_fault,
    output logic [PA_W-1:0]            rsp_paddr,
    output logic                       rsp_rd,
    output logic                       rsp_wr,
    output logic                       rsp_ex,
    output logic                       rsp_dirty,
    output logic                       walk_req,
    output logic [VA_W-PAGE_OFF_W-1:0] walk_vpn,
    input  logic                       fill_valid,
    input  logic [VA_W-PAGE_OFF_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_OFF_W-1:0] fill_ppn,
    input  logic                       fill_rd,
    input  logic                       fill_wr,
    input  logic                       fill_ex,
    input  logic                       fill_dirty,
    input  logic                       flush,
    input  logic                       inv_valid,
    input  logic [VA_W-PAGE_OFF_W-1:0] inv_vpn
);
    localparam int VPN_W  = VA_W - PAGE_OFF_W;
    localparam int PPN_W  = PA_W - PAGE_OFF_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int N_KEYS = 3;

    logic [ENTRIES-1:0] ent_vld;
    logic [VPN_W-1:0]   ent_tag  [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
    perm_t              ent_perm [ENTRIES];

    logic [VPN_W-1:0]   keys [N_KEYS];
    logic [ENTRIES-1:0] hits [N_KEYS];
    logic [ENTRIES-1:0] lk_hitv;
    logic [ENTRIES-1:0] fill_hitv;
    logic [ENTRIES-1:0] inv_hitv;

    assign keys[0] = lk_vaddr[VA_W-1:PAGE_OFF_W];
    assign keys[1] = fill_vpn;
    assign keys[2] = inv_vpn;

    for (genvar p = 0; p < N_KEYS; p++) begin : g_match
        xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) match_i (
            .vld (ent_vld),
            .tags(ent_tag),
            .key (keys[p]),
            .hit (hits[p])
        );
    end

    assign lk_hitv   = hits[0];
    assign fill_hitv = hits[1];
    assign inv_hitv  = inv_valid ? hits[2] : '0;

    // Fill is dropped under a flush or under an invalidate of the same page.
    logic             fill_fire;
    logic [IDX_W-1:0] fill_idx;
    perm_t            fill_perm;

    assign fill_fire = fill_valid && !flush && !(inv_valid && (inv_vpn == fill_vpn));
    assign fill_perm = '{rd: fill_rd, wr: fill_wr, ex: fill_ex, dirty: fill_dirty};

    xlat_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk    (clk),
        .rst    (rst),
        .vld    (ent_vld),
        .dup_hit(fill_hitv),
        .fire   (fill_fire),
        .idx    (fill_idx)
    );

    xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) store_i (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_en  (fill_fire),
        .wr_idx (fill_idx),
        .wr_tag (fill_vpn),
        .wr_ppn (fill_ppn),
        .wr_perm(fill_perm),
        .clr_vec(inv_hitv),
        .vld    (ent_vld),
        .tags   (ent_tag),
        .ppns   (ent_ppn),
        .perms  (ent_perm)
    );

    // One-hot read selection across the matching entry.
    logic [PPN_W-1:0] sel_ppn;
    logic [3:0]       sel_perm_bits;
    perm_t            sel_perm;
    logic             lk_hit;
    logic             lk_ok;

    always_comb begin
        sel_ppn       = '0;
        sel_perm_bits = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_ppn       = sel_ppn | ({PPN_W{lk_hitv[i]}} & ent_ppn[i]);
            sel_perm_bits = sel_perm_bits | ({4{lk_hitv[i]}} & ent_perm[i]);
        end
        sel_perm = perm_t'(sel_perm_bits);
        lk_hit   = lk_valid && (|lk_hitv);
        lk_ok    = perm_allows(sel_perm, acc_kind_e'(lk_kind));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
            rsp_dirty <= 1'b0;
            walk_req  <= 1'b0;
            walk_vpn  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_hit;
            rsp_fault <= lk_hit && !lk_ok;
            rsp_paddr <= (lk_hit && lk_ok) ? {sel_ppn, lk_vaddr[PAGE_OFF_W-1:0]} : '0;
            rsp_rd    <= lk_hit && sel_perm.rd;
            rsp_wr    <= lk_hit && sel_perm.wr;
            rsp_ex    <= lk_hit && sel_perm.ex;
            rsp_dirty <= lk_hit && sel_perm.dirty;
            walk_req  <= lk_valid && !lk_hit;
            walk_vpn  <= (lk_valid && !lk_hit) ? keys[0] : '0;
        end
    end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               walk_req,
    input logic               flush,
    input logic [ENTRIES-1:0] ent_vld,
    input logic [ENTRIES-1:0] lk_hitv
);
    // R2: each lookup is answered on the following cycle
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R2: a permitted hit keeps the page offset of the request
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && !rsp_fault) |->
            rsp_paddr[PAGE_OFF_W-1:0] == $past(lk_vaddr[PAGE_OFF_W-1:0]));

    // R3: a walk is requested only for a missed lookup
    a_r3_walk_on_miss: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> (rsp_valid && !rsp_hit));

    // R8: a fault only comes with a hit and never carries an address
    a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_hit && rsp_paddr == '0));

    // R9: after a flush no entry is valid
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ent_vld == '0));

    // R7: no page is held in more than one entry
    a_r7_single_match: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(lk_hitv));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr),
    .walk_req (walk_req),
    .flush    (flush),
    .ent_vld  (ent_vld),
    .lk_hitv  (lk_hitv)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int VW   = 20;
    localparam int PW   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [1:0] lk_kind = '0;
    logic rsp_valid, rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_ex, rsp_dirty, walk_req;
    logic [PA_W-1:0] rsp_paddr;
    logic [VW-1:0] walk_vpn;
    logic fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic fill_rd = 0, fill_wr = 0, fill_ex = 0, fill_dirty = 0;
    logic flush = 1'b0;
    logic inv_valid = 1'b0;
    logic [VW-1:0] inv_vpn = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .rsp_ex(rsp_ex), .rsp_dirty(rsp_dirty),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_dirty(fill_dirty),
        .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference table, maintained from the requirement text
    bit            m_v    [N];
    logic [VW-1:0] m_tag  [N];
    logic [PW-1:0] m_ppn  [N];
    logic [3:0]    m_perm [N];   // {rd, wr, ex, dirty}
    int            m_rr = 0;

    logic [VW-1:0] seen [64];
    int            n_seen = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [VW-1:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    task automatic note_seen(logic [VW-1:0] vpn);
        for (int i = 0; i < n_seen; i++) if (seen[i] == vpn) return;
        seen[n_seen] = vpn;
        n_seen++;
    endtask

    task automatic m_install(logic [VW-1:0] vpn, logic [PW-1:0] ppn, logic [3:0] perm);
        int k;
        k = m_find(vpn);                                    // R7 overwrite in place
        if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;  // R5 lowest free
        if (k < 0) begin k = m_rr; m_rr = (m_rr + 1) % N; end            // R6 round robin
        m_v[k] = 1; m_tag[k] = vpn; m_ppn[k] = ppn; m_perm[k] = perm;
    endtask

    task automatic drive_fill(logic [VW-1:0] vpn, logic [PW-1:0] ppn, logic [3:0] perm);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
        {fill_rd, fill_wr, fill_ex, fill_dirty} = perm;
    endtask

    task automatic fill(logic [VW-1:0] vpn, logic [PW-1:0] ppn, logic [3:0] perm);
        @(negedge clk);
        drive_fill(vpn, ppn, perm);
        @(negedge clk);
        fill_valid = 0;
        m_install(vpn, ppn, perm);
        note_seen(vpn);
    endtask

    task automatic check_rsp(string req, logic [VW-1:0] vpn, logic [11:0] off, logic [1:0] kind,
                             int k);
        bit hit, ok;
        logic [3:0] p;
        hit = (k >= 0);
        p   = hit ? m_perm[k] : 4'b0;
        ok  = (kind == 2'b01) ? p[2] : (kind == 2'b10) ? p[1] : p[3];
        chk(req, "rsp_valid", rsp_valid, 1);
        chk(req, "rsp_hit", rsp_hit, hit);
        chk(req, "rsp_fault", rsp_fault, hit && !ok);                  // R8
        chk(req, "rsp_paddr", rsp_paddr, (hit && ok) ? {m_ppn[k], off} : 32'h0);
        chk(req, "perm", {rsp_rd, rsp_wr, rsp_ex, rsp_dirty}, p);
        chk(req, "walk_req", walk_req, !hit);                          // R3
        chk(req, "walk_vpn", walk_vpn, hit ? '0 : vpn);
    endtask

    task automatic lookup(string req, logic [VW-1:0] vpn, logic [11:0] off, logic [1:0] kind);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_kind = kind;
        @(negedge clk);
        lk_valid = 0;
        check_rsp(req, vpn, off, kind, m_find(vpn));
    endtask

    task automatic sweep(string req);
        for (int j = 0; j < n_seen; j++)
            for (int kd = 0; kd < 4; kd++)
                lookup(req, seen[j], 12'((j * 37 + kd * 421) & 12'hfff), 2'(kd));
    endtask

    initial begin
        repeat (CLK_PERIOD) @(posedge clk);
        if (!done) begin end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle outputs after reset, and the first lookup misses
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "walk_req", walk_req, 0);
        lookup("R1", 20'h00005, 12'h3a1, 2'b00);

        // R2 R4 R8: fill every slot, permissions sweep the 3 permission bits
        for (int i = 0; i < N; i++)
            fill(20'h00100 + 20'(i * 'h111), 20'h0a000 + 20'(i * 3),
                 {i[0], i[1], i[2], i[0] ^ i[1]});
        sweep("R2");
        sweep("R8");

        // R6: table full, new pages go to slots 0 then 1
        fill(20'h00900, 20'h0beef, 4'b1110);
        fill(20'h00901, 20'h0bef0, 4'b1001);
        sweep("R6");

        // R7: refill an existing page with a new frame and permissions
        fill(20'h00322, 20'h0c0de, 4'b1111);
        sweep("R7");

        // R10: invalidate one page, the rest stay
        @(negedge clk); inv_valid = 1; inv_vpn = 20'h00433;
        @(negedge clk); inv_valid = 0;
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == 20'h00433) m_v[i] = 0;
        sweep("R10");

        // R5: the next new page takes the hole, nothing else evicted
        fill(20'h00777, 20'h0d00d, 4'b1100);
        sweep("R5");
        // R6: pointer was left at 2 by the earlier replacements
        fill(20'h00778, 20'h0d00e, 4'b1010);
        sweep("R6");

        // R9: flush with a fill in the same cycle keeps nothing
        @(negedge clk); flush = 1; drive_fill(20'h00abc, 20'h01234, 4'b1111);
        @(negedge clk); flush = 0; fill_valid = 0;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        note_seen(20'h00abc);
        sweep("R9");

        // R5: after a flush slots fill from the lowest index, pointer unchanged
        fill(20'h00abc, 20'h01234, 4'b1000);
        fill(20'h00abd, 20'h01235, 4'b0100);
        sweep("R5");

        // R10: invalidate and fill of one page together leave it absent
        @(negedge clk); inv_valid = 1; inv_vpn = 20'h00abd;
        drive_fill(20'h00abd, 20'h05555, 4'b1111);
        @(negedge clk); inv_valid = 0; fill_valid = 0;
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == 20'h00abd) m_v[i] = 0;
        lookup("R10", 20'h00abd, 12'h010, 2'b00);

        // R4: lookup in the fill cycle sees the old table, next one hits
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {20'h00e01, 12'h456}; lk_kind = 2'b00;
        drive_fill(20'h00e01, 20'h07777, 4'b1001);
        @(negedge clk);
        lk_valid = 0; fill_valid = 0;
        check_rsp("R4", 20'h00e01, 12'h456, 2'b00, m_find(20'h00e01));
        m_install(20'h00e01, 20'h07777, 4'b1001);
        note_seen(20'h00e01);
        lookup("R4", 20'h00e01, 12'h456, 2'b00);
        sweep("R4");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule